// File: doc/BRIEF.md
# OUT Endpoint Transaction Responder

This block handles the receive half of OUT transactions on a USB-style device for one control endpoint (number 0) and a set of general endpoints, each owning a private receive FIFO. When a decoded OUT token arrives for a valid endpoint, the block pushes the following data bytes straight into that endpoint's FIFO. It does not check beforehand whether the whole packet will fit. The bytes are held behind a speculative write pointer. When the end-of-packet strobe arrives, the block picks one outcome. It either commits the bytes, so the read side can see them, or it rolls the speculative pointer back. It then drives one handshake code, or none, and pulses per-endpoint event flags.

The expected data toggle of each endpoint advances only on a committed packet. A packet shorter than the endpoint maximum is a short packet. On a general endpoint, a short packet raises a short event. Unless a per-endpoint disable bit is set, it also arms a force-NAK flag. While that flag is set, later packets to the endpoint are refused with NAK. Firmware clears the flag through a pulse input. A minimal pop port on the read side exposes committed bytes so that the data can be drained.

The controlling state machine has three states:
- `S_IDLE` waits for a token. The transition `tok_accept` (valid token, endpoint number below `NUM_EP`) leads to `S_RECV`.
- `S_RECV` takes bytes. The transition `eop_seen` leads to `S_REPLY`.
- `S_REPLY` lasts exactly one cycle. During it the handshake and events are driven and commit or rollback happens. The transition `reply_done` returns to `S_IDLE`.

Top module: `out_ep_responder`

## Requirements
- R1: Bytes received for an endpoint are written into its FIFO without any prior free-space check, but `rx_level` for that endpoint does not change while the packet is still arriving. Only committed bytes are ever counted or readable.
- R2: A packet with no error, at most `MAX_PKT` bytes, enough FIFO room, the expected toggle, and force-NAK clear is committed. The block answers `hs_code` = 2'b01 (ACK) with `hs_valid` in the cycle after the end-of-packet strobe, pulses `evt_ack` for that endpoint, and `rx_level` grows by the byte count one cycle later.
- R3: A committed packet with fewer than `MAX_PKT` bytes (zero bytes included) on a general endpoint (number 1 or above) also pulses `evt_short`. Endpoint 0 never raises `evt_short`.
- R4: A committed short packet on a general endpoint sets `force_nak` for that endpoint when `dis_auto_nak` for it is 0, and leaves `force_nak` unchanged when that bit is 1. Endpoint 0 never sets `force_nak` this way.
- R5: A packet whose PID toggle (`tok_data1`, 0 = DATA0, 1 = DATA1) differs from `exp_toggle` of the endpoint is answered with ACK. No event is raised, the FIFO level stays the same, and the toggle stays the same.
- R6: A packet ending with `eop_err` = 1, or carrying more than `MAX_PKT` bytes, gets no handshake (`hs_valid` stays 0). It pulses `evt_err` and leaves the FIFO level and the toggle unchanged. This outcome takes precedence over all others.
- R7: If the FIFO fills before the last byte arrives, the block answers NAK (`hs_code` = 2'b10) and discards the packet. It pulses `evt_nak` only for general endpoints.
- R8: If `force_nak` of the endpoint is set when the token is accepted, nothing is written. The block answers NAK and pulses `evt_nak` for general endpoints only. The level and the toggle stay the same.
- R9: `exp_toggle` resets to 0 (DATA0) and flips only when that endpoint commits a packet.
- R10: After reset every `force_nak` is 0 and every level is 0. A pulse on `nak_clr[e]` clears `force_nak[e]`.
- R11: A token whose endpoint number is `NUM_EP` or higher is ignored. The bytes and end-of-packet that follow it produce no handshake and no event.
- R12: With `rd_ep` selecting an endpoint, `rd_data` shows the oldest committed byte. Each `rd_pop` advances to the next byte, and bytes come out in the order they were received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Decoded OUT token strobe |
| tok_ep | input | EP_W | Endpoint number of the token |
| tok_data1 | input | 1 | PID toggle of the data packet, 1 = DATA1 |
| rx_valid | input | 1 | Received data byte strobe |
| rx_byte | input | 8 | Received data byte |
| eop_valid | input | 1 | End-of-packet strobe |
| eop_err | input | 1 | Reception error flag, qualified by eop_valid |
| dis_auto_nak | input | NUM_EP | Per endpoint: suppress force-NAK arming on short packets |
| nak_clr | input | NUM_EP | Per endpoint: clear force-NAK |
| hs_valid | output | 1 | Handshake is sent this cycle |
| hs_code | output | 2 | 01 = ACK, 10 = NAK |
| evt_ack | output | NUM_EP | Transaction-ACK event pulse |
| evt_short | output | NUM_EP | Short-packet-ACK event pulse |
| evt_nak | output | NUM_EP | Transaction-NAK event pulse |
| evt_err | output | NUM_EP | Transaction-error event pulse |
| force_nak | output | NUM_EP | Force-NAK flag per endpoint |
| exp_toggle | output | NUM_EP | Expected data toggle per endpoint |
| rd_ep | input | EP_W | Endpoint selected for reading |
| rd_pop | input | 1 | Pop one committed byte from the selected FIFO |
| rd_data | output | 8 | Oldest committed byte of the selected FIFO |
| rx_level | output | NUM_EP*LVL_W | Committed byte count per endpoint, endpoint e at bits [e*LVL_W +: LVL_W] |

## Verification
The bench builds the block with five endpoints, an 8-byte FIFO and a 4-byte maximum packet. At these sizes every packet length from zero up to one byte beyond the maximum can be swept on every endpoint, with auto-NAK both enabled and disabled. A FIFO can also be filled with two full packets, which makes the overflow NAK and the zero-length fit-when-full cases cheap to reach. Toggle mismatch, reception error, forced NAK and out-of-range endpoint numbers are then applied on top of the model state the sweep leaves behind. Each expected outcome is worked out from the requirement priorities and a byte-queue model.

// File: rtl/out_ep_pkg.sv
package out_ep_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RECV  = 2'd1,
        S_REPLY = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        HS_NONE = 2'b00,
        HS_ACK  = 2'b01,
        HS_NAK  = 2'b10
    } hs_e;

    typedef enum logic [2:0] {
        OC_GOOD     = 3'd0,
        OC_MISMATCH = 3'd1,
        OC_OVERFLOW = 3'd2,
        OC_FORCED   = 3'd3,
        OC_ERROR    = 3'd4
    } outcome_e;

endpackage

// File: rtl/ep_rx_fifo.sv
// Receive FIFO with a speculative and a committed write pointer.
// DEPTH must be a power of two.
module ep_rx_fifo #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          commit,
    input  logic          rollback,
    input  logic          pop,
    output logic          full,
    output logic [PW-1:0] level,
    output logic [7:0]    rd_data
);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] spec_ptr;
    logic [PW-1:0] com_ptr;
    logic [PW-1:0] rd_ptr;

    assign full    = (spec_ptr - rd_ptr) == PW'(DEPTH);
    assign level   = com_ptr - rd_ptr;
    assign rd_data = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_ptr <= '0;
            com_ptr  <= '0;
            rd_ptr   <= '0;
        end else begin
            if (rollback) begin
                spec_ptr <= com_ptr;
            end else if (wr_en && !full) begin
                spec_ptr <= spec_ptr + 1'b1;
            end
            if (commit) begin
                com_ptr <= spec_ptr;
            end
            if (pop && (level != '0)) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full) begin
            mem[spec_ptr[AW-1:0]] <= wr_data;
        end
    end

endmodule

// File: rtl/out_ep_verdict.sv
// Picks the end-of-packet outcome and the actions that follow from it.
module out_ep_verdict
    import out_ep_pkg::*;
#(
    parameter int MAX_PKT = 8,
    localparam int CNT_W = $clog2(MAX_PKT + 2)
) (
    input  logic             err_i,
    input  logic             big_i,
    input  logic             forced_i,
    input  logic             ovf_i,
    input  logic             pid_i,
    input  logic             exp_tog_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             general_i,
    input  logic             dis_nak_i,
    output hs_e              hs_o,
    output logic             ev_ack_o,
    output logic             ev_short_o,
    output logic             ev_nak_o,
    output logic             ev_err_o,
    output logic             commit_o,
    output logic             rollback_o,
    output logic             set_fnak_o,
    output logic             flip_tog_o
);

    outcome_e oc;
    logic     is_short;

    assign is_short = (cnt_i < CNT_W'(MAX_PKT)) && general_i;

    always_comb begin
        if (err_i || big_i) begin
            oc = OC_ERROR;
        end else if (forced_i) begin
            oc = OC_FORCED;
        end else if (ovf_i) begin
            oc = OC_OVERFLOW;
        end else if (pid_i != exp_tog_i) begin
            oc = OC_MISMATCH;
        end else begin
            oc = OC_GOOD;
        end
    end

    always_comb begin
        hs_o       = HS_NONE;
        ev_ack_o   = 1'b0;
        ev_short_o = 1'b0;
        ev_nak_o   = 1'b0;
        ev_err_o   = 1'b0;
        commit_o   = 1'b0;
        rollback_o = 1'b0;
        set_fnak_o = 1'b0;
        flip_tog_o = 1'b0;
        unique case (oc)
            OC_ERROR: begin
                ev_err_o   = 1'b1;
                rollback_o = 1'b1;
            end
            OC_FORCED, OC_OVERFLOW: begin
                hs_o       = HS_NAK;
                ev_nak_o   = general_i;
                rollback_o = 1'b1;
            end
            OC_MISMATCH: begin
                hs_o       = HS_ACK;
                rollback_o = 1'b1;
            end
            OC_GOOD: begin
                hs_o       = HS_ACK;
                ev_ack_o   = 1'b1;
                commit_o   = 1'b1;
                flip_tog_o = 1'b1;
                ev_short_o = is_short;
                set_fnak_o = is_short && !dis_nak_i;
            end
            default: begin
                hs_o = HS_NONE;
            end
        endcase
    end

endmodule

// File: rtl/out_ep_responder.sv
module out_ep_responder
    import out_ep_pkg::*;
#(
    parameter int NUM_EP     = 5,
    parameter int FIFO_DEPTH = 16,
    parameter int MAX_PKT    = 8,
    localparam int EP_W  = $clog2(NUM_EP),
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1,
    localparam int CNT_W = $clog2(MAX_PKT + 2)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tok_valid,
    input  logic [EP_W-1:0]         tok_ep,
    input  logic                    tok_data1,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    input  logic                    eop_valid,
    input  logic                    eop_err,
    input  logic [NUM_EP-1:0]       dis_auto_nak,
    input  logic [NUM_EP-1:0]       nak_clr,
    output logic                    hs_valid,
    output logic [1:0]              hs_code,
    output logic [NUM_EP-1:0]       evt_ack,
    output logic [NUM_EP-1:0]       evt_short,
    output logic [NUM_EP-1:0]       evt_nak,
    output logic [NUM_EP-1:0]       evt_err,
    output logic [NUM_EP-1:0]       force_nak,
    output logic [NUM_EP-1:0]       exp_toggle,
    input  logic [EP_W-1:0]         rd_ep,
    input  logic                    rd_pop,
    output logic [7:0]              rd_data,
    output logic [NUM_EP*LVL_W-1:0] rx_level
);

    rx_state_e state, state_nx;

    logic [EP_W-1:0]   ep_r;
    logic              pid_r;
    logic [CNT_W-1:0]  cnt_r;
    logic              ovf_r;
    logic              big_r;
    logic              err_r;
    logic              forced_r;
    logic [NUM_EP-1:0] tog_r;
    logic [NUM_EP-1:0] fnak_r;

    logic tok_accept;
    logic eop_seen;
    logic at_max;
    logic in_reply;

    logic [NUM_EP-1:0] full_v;
    logic [NUM_EP-1:0] wr_v;
    logic [NUM_EP-1:0] pop_v;
    logic [NUM_EP-1:0] com_v;
    logic [NUM_EP-1:0] rb_v;
    logic [7:0]        rdd   [NUM_EP];
    logic [LVL_W-1:0]  lvl   [NUM_EP];

    hs_e  v_hs;
    logic v_ack, v_short, v_nak, v_err, v_commit, v_rollback, v_set_fnak, v_flip;

    assign tok_accept = (state == S_IDLE) && tok_valid && (int'(tok_ep) < NUM_EP);
    assign eop_seen   = (state == S_RECV) && eop_valid;
    assign at_max     = (cnt_r == CNT_W'(MAX_PKT));
    assign in_reply   = (state == S_REPLY);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (tok_accept) state_nx = S_RECV;
            S_RECV:  if (eop_seen)   state_nx = S_REPLY;
            S_REPLY: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Per-packet context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ep_r     <= '0;
            pid_r    <= 1'b0;
            cnt_r    <= '0;
            ovf_r    <= 1'b0;
            big_r    <= 1'b0;
            err_r    <= 1'b0;
            forced_r <= 1'b0;
        end else if (tok_accept) begin
            ep_r     <= tok_ep;
            pid_r    <= tok_data1;
            cnt_r    <= '0;
            ovf_r    <= 1'b0;
            big_r    <= 1'b0;
            err_r    <= 1'b0;
            forced_r <= fnak_r[tok_ep];
        end else if (state == S_RECV) begin
            if (rx_valid) begin
                if (at_max) begin
                    big_r <= 1'b1;
                end else begin
                    cnt_r <= cnt_r + 1'b1;
                end
                if (!forced_r && !at_max && full_v[ep_r]) begin
                    ovf_r <= 1'b1;
                end
            end
            if (eop_valid) begin
                err_r <= eop_err;
            end
        end
    end

    out_ep_verdict #(
        .MAX_PKT (MAX_PKT)
    ) u_verdict (
        .err_i      (err_r),
        .big_i      (big_r),
        .forced_i   (forced_r),
        .ovf_i      (ovf_r),
        .pid_i      (pid_r),
        .exp_tog_i  (tog_r[ep_r]),
        .cnt_i      (cnt_r),
        .general_i  (ep_r != '0),
        .dis_nak_i  (dis_auto_nak[ep_r]),
        .hs_o       (v_hs),
        .ev_ack_o   (v_ack),
        .ev_short_o (v_short),
        .ev_nak_o   (v_nak),
        .ev_err_o   (v_err),
        .commit_o   (v_commit),
        .rollback_o (v_rollback),
        .set_fnak_o (v_set_fnak),
        .flip_tog_o (v_flip)
    );

    // Output process
    always_comb begin
        hs_valid  = in_reply && (v_hs != HS_NONE);
        hs_code   = in_reply ? v_hs : HS_NONE;
        evt_ack   = '0;
        evt_short = '0;
        evt_nak   = '0;
        evt_err   = '0;
        com_v     = '0;
        rb_v      = '0;
        if (in_reply) begin
            evt_ack[ep_r]   = v_ack;
            evt_short[ep_r] = v_short;
            evt_nak[ep_r]   = v_nak;
            evt_err[ep_r]   = v_err;
            com_v[ep_r]     = v_commit;
            rb_v[ep_r]      = v_rollback;
        end
    end

    // Toggle and force-NAK flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_r  <= '0;
            fnak_r <= '0;
        end else begin
            for (int e = 0; e < NUM_EP; e++) begin
                if (in_reply && (int'(ep_r) == e) && v_flip) begin
                    tog_r[e] <= ~tog_r[e];
                end
                if (in_reply && (int'(ep_r) == e) && v_set_fnak) begin
                    fnak_r[e] <= 1'b1;
                end else if (nak_clr[e]) begin
                    fnak_r[e] <= 1'b0;
                end
            end
        end
    end

    assign force_nak  = fnak_r;
    assign exp_toggle = tog_r;

    genvar g;
    generate
        for (g = 0; g < NUM_EP; g++) begin : g_ep
            assign wr_v[g]  = (state == S_RECV) && rx_valid && !forced_r && !at_max
                              && !ovf_r && (int'(ep_r) == g);
            assign pop_v[g] = rd_pop && (int'(rd_ep) == g);

            ep_rx_fifo #(
                .DEPTH (FIFO_DEPTH)
            ) u_fifo (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_v[g]),
                .wr_data  (rx_byte),
                .commit   (com_v[g]),
                .rollback (rb_v[g]),
                .pop      (pop_v[g]),
                .full     (full_v[g]),
                .level    (lvl[g]),
                .rd_data  (rdd[g])
            );

            assign rx_level[g*LVL_W +: LVL_W] = lvl[g];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int e = 0; e < NUM_EP; e++) begin
            if (int'(rd_ep) == e) begin
                rd_data = rdd[e];
            end
        end
    end

endmodule

// File: rtl/out_ep_responder_chk.sv
module out_ep_responder_chk #(
    parameter int NUM_EP = 5,
    parameter int LVL_W  = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    hs_valid,
    input logic [1:0]              hs_code,
    input logic [NUM_EP-1:0]       evt_ack,
    input logic [NUM_EP-1:0]       evt_short,
    input logic [NUM_EP-1:0]       evt_nak,
    input logic [NUM_EP-1:0]       evt_err,
    input logic [NUM_EP-1:0]       force_nak,
    input logic [NUM_EP-1:0]       exp_toggle,
    input logic [NUM_EP*LVL_W-1:0] rx_level
);

    // R2: a commit event always travels with an ACK handshake
    p_ack_hs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_ack) |-> (hs_valid && hs_code == 2'b01));

    // R6: an error event is never accompanied by a handshake
    p_err_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_err) |-> !hs_valid);

    // R7: a NAK event always travels with a NAK handshake
    p_nak_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_nak) |-> (hs_valid && hs_code == 2'b10));

    // R3: short event only alongside an ACK event of the same endpoint, never on endpoint 0
    p_short_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_short & ~evt_ack) == '0) && !evt_short[0]);

    genvar e;
    generate
        for (e = 0; e < NUM_EP; e++) begin : g_chk
            // R1: committed level grows only right after a commit of that endpoint
            p_level_grow_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (rx_level[e*LVL_W +: LVL_W] > $past(rx_level[e*LVL_W +: LVL_W]))
                |-> $past(evt_ack[e]));

            // R9: toggle changes only right after a commit of that endpoint
            p_toggle_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (exp_toggle[e] != $past(exp_toggle[e])) |-> $past(evt_ack[e]));

            // R4: force-NAK rises only right after a short event
            p_fnak_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(force_nak[e]) |-> $past(evt_short[e]));
        end
    endgenerate

endmodule

bind out_ep_responder out_ep_responder_chk #(
    .NUM_EP (NUM_EP),
    .LVL_W  (LVL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_valid   (hs_valid),
    .hs_code    (hs_code),
    .evt_ack    (evt_ack),
    .evt_short  (evt_short),
    .evt_nak    (evt_nak),
    .evt_err    (evt_err),
    .force_nak  (force_nak),
    .exp_toggle (exp_toggle),
    .rx_level   (rx_level)
);

// File: tb/out_ep_responder_bench.sv
`timescale 1ns/1ps
module out_ep_responder_bench;

    localparam int NEP   = 5;
    localparam int DEP   = 8;
    localparam int MAXP  = 4;
    localparam int EPW   = $clog2(NEP);
    localparam int LW    = $clog2(DEP) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tok_valid = 1'b0;
    logic [EPW-1:0]   tok_ep = '0;
    logic             tok_data1 = 1'b0;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_byte = '0;
    logic             eop_valid = 1'b0;
    logic             eop_err = 1'b0;
    logic [NEP-1:0]   dis_auto_nak = '0;
    logic [NEP-1:0]   nak_clr = '0;
    logic             hs_valid;
    logic [1:0]       hs_code;
    logic [NEP-1:0]   evt_ack, evt_short, evt_nak, evt_err;
    logic [NEP-1:0]   force_nak, exp_toggle;
    logic [EPW-1:0]   rd_ep = '0;
    logic             rd_pop = 1'b0;
    logic [7:0]       rd_data;
    logic [NEP*LW-1:0] rx_level;

    out_ep_responder #(.NUM_EP(NEP), .FIFO_DEPTH(DEP), .MAX_PKT(MAXP)) u_out_ep_responder (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ep(tok_ep),
        .tok_data1(tok_data1), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .eop_valid(eop_valid), .eop_err(eop_err), .dis_auto_nak(dis_auto_nak),
        .nak_clr(nak_clr), .hs_valid(hs_valid), .hs_code(hs_code),
        .evt_ack(evt_ack), .evt_short(evt_short), .evt_nak(evt_nak), .evt_err(evt_err),
        .force_nak(force_nak), .exp_toggle(exp_toggle), .rd_ep(rd_ep),
        .rd_pop(rd_pop), .rd_data(rd_data), .rx_level(rx_level)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int seq     = 0;

    logic [7:0] mq   [NEP][DEP];
    int         mhd  [NEP];
    int         mcnt [NEP];
    bit         mtog [NEP];
    bit         mfn  [NEP];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lvl_of(input int ep);
        return int'(rx_level[ep*LW +: LW]);
    endfunction

    function automatic logic [7:0] byte_val(input int ep, input int s, input int i);
        return 8'((ep * 53) ^ (s * 7 + i * 3));
    endfunction

    // Sends one packet and checks the result against the model.
    task automatic run_pkt(input int ep, input bit pid, input int len, input bit err);
        int  free;
        int  oc;        // 0 good, 1 mismatch, 2 overflow, 3 forced, 4 error
        bit  gen;
        bit  shrt;
        int  lvl0;
        logic [NEP-1:0] e_ack, e_short, e_nak, e_err;
        bit  e_hsv;
        int  e_code;
        seq++;
        gen  = (ep != 0);
        free = DEP - mcnt[ep];
        lvl0 = mcnt[ep];
        if (err || len > MAXP)      oc = 4;
        else if (mfn[ep])           oc = 3;
        else if (len > free)        oc = 2;
        else if (pid != mtog[ep])   oc = 1;
        else                        oc = 0;
        shrt = (len < MAXP) && gen;
        e_ack = '0; e_short = '0; e_nak = '0; e_err = '0;
        e_hsv = (oc != 4);
        e_code = (oc == 2 || oc == 3) ? 2 : (oc == 4 ? 0 : 1);
        if (oc == 0) begin e_ack[ep] = 1'b1; e_short[ep] = shrt; end
        if ((oc == 2 || oc == 3) && gen) e_nak[ep] = 1'b1;
        if (oc == 4) e_err[ep] = 1'b1;

        @(negedge clk);
        tok_valid = 1'b1; tok_ep = EPW'(ep); tok_data1 = pid;
        @(negedge clk);
        tok_valid = 1'b0;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1; rx_byte = byte_val(ep, seq, i);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        chk(lvl_of(ep) == lvl0, "R1 level hidden during reception", lvl_of(ep), lvl0);
        eop_valid = 1'b1; eop_err = err;
        @(negedge clk);
        eop_valid = 1'b0; eop_err = 1'b0;
        chk(hs_valid == e_hsv, (oc == 4) ? "R6 no handshake" : "R2/R5/R7/R8 hs_valid",
            int'(hs_valid), int'(e_hsv));
        chk(int'(hs_code) == e_code,
            (oc == 2) ? "R7 overflow NAK" : (oc == 3) ? "R8 forced NAK" :
            (oc == 1) ? "R5 mismatch ACK" : "R2 hs_code", int'(hs_code), e_code);
        chk(evt_ack == e_ack, "R2 evt_ack", int'(evt_ack), int'(e_ack));
        chk(evt_short == e_short, "R3 evt_short", int'(evt_short), int'(e_short));
        chk(evt_nak == e_nak, "R7 evt_nak", int'(evt_nak), int'(e_nak));
        chk(evt_err == e_err, "R6 evt_err", int'(evt_err), int'(e_err));

        if (oc == 0) begin
            for (int i = 0; i < len; i++) begin
                mq[ep][(mhd[ep] + mcnt[ep]) % DEP] = byte_val(ep, seq, i);
                mcnt[ep]++;
            end
            mtog[ep] = !mtog[ep];
            if (shrt && !dis_auto_nak[ep]) mfn[ep] = 1'b1;
        end
        @(negedge clk);
        chk(lvl_of(ep) == mcnt[ep], "R2 committed level", lvl_of(ep), mcnt[ep]);
        chk(exp_toggle[ep] == mtog[ep], "R9 toggle", int'(exp_toggle[ep]), int'(mtog[ep]));
        chk(force_nak[ep] == mfn[ep], "R4 force_nak", int'(force_nak[ep]), int'(mfn[ep]));
    endtask

    task automatic drain(input int ep);
        int n;
        n = mcnt[ep];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_ep = EPW'(ep);
            #1;
            chk(rd_data == mq[ep][mhd[ep]], "R12 read order", int'(rd_data), int'(mq[ep][mhd[ep]]));
            rd_pop = 1'b1;
            mhd[ep] = (mhd[ep] + 1) % DEP;
            mcnt[ep]--;
            @(negedge clk);
            rd_pop = 1'b0;
        end
        @(negedge clk);
        chk(lvl_of(ep) == 0, "R12 drained level", lvl_of(ep), 0);
    endtask

    task automatic clear_nak(input int ep);
        @(negedge clk);
        nak_clr = NEP'(1) << ep;
        @(negedge clk);
        nak_clr = '0;
        mfn[ep] = 1'b0;
        chk(force_nak[ep] == 1'b0, "R10 nak_clr", int'(force_nak[ep]), 0);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int e = 0; e < NEP; e++) begin
            mhd[e] = 0; mcnt[e] = 0; mtog[e] = 1'b0; mfn[e] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(force_nak == '0, "R10 reset force_nak", int'(force_nak), 0);
        chk(exp_toggle == '0, "R9 reset toggle", int'(exp_toggle), 0);
        chk(rx_level == '0, "R10 reset level", int'(rx_level), 0);
        chk(hs_valid == 1'b0, "R10 reset hs", int'(hs_valid), 0);

        // Length sweep on every endpoint, auto-NAK enabled then disabled
        for (int pass = 0; pass < 2; pass++) begin
            dis_auto_nak = (pass == 0) ? '0 : '1;
            for (int e = 0; e < NEP; e++) begin
                for (int len = 0; len <= MAXP + 1; len++) begin
                    run_pkt(e, mtog[e], len, 1'b0);
                    drain(e);
                    if (mfn[e]) clear_nak(e);
                end
            end
        end

        // R5 mismatch and R6 error on each endpoint
        dis_auto_nak = '0;
        for (int e = 0; e < NEP; e++) begin
            run_pkt(e, !mtog[e], 2, 1'b0);
            run_pkt(e, mtog[e], 3, 1'b1);
            run_pkt(e, mtog[e], MAXP, 1'b0);
            drain(e);
        end

        // R8 forced NAK: arm by a short packet, then send again
        run_pkt(1, mtog[1], 2, 1'b0);
        run_pkt(1, mtog[1], 3, 1'b0);
        run_pkt(1, mtog[1], 0, 1'b1);
        clear_nak(1);
        run_pkt(1, mtog[1], MAXP, 1'b0);
        drain(1);

        // R7 overflow on a general endpoint and on endpoint 0
        for (int k = 0; k < 2; k++) begin
            int e;
            e = (k == 0) ? 2 : 0;
            run_pkt(e, mtog[e], MAXP, 1'b0);
            run_pkt(e, mtog[e], MAXP, 1'b0);
            run_pkt(e, mtog[e], 1, 1'b0);
            run_pkt(e, mtog[e], 0, 1'b0);
            drain(e);
            if (mfn[e]) clear_nak(e);
        end

        // R11 tokens for endpoints outside the range
        for (int e = NEP; e < (1 << EPW); e++) begin
            @(negedge clk);
            tok_valid = 1'b1; tok_ep = EPW'(e); tok_data1 = 1'b0;
            @(negedge clk);
            tok_valid = 1'b0; rx_valid = 1'b1; rx_byte = 8'hA5;
            @(negedge clk);
            rx_valid = 1'b0; eop_valid = 1'b1;
            @(negedge clk);
            eop_valid = 1'b0;
            chk(hs_valid == 1'b0, "R11 no handshake", int'(hs_valid), 0);
            chk((evt_ack | evt_nak | evt_err) == '0, "R11 no event",
                int'(evt_ack | evt_nak | evt_err), 0);
            @(negedge clk);
            chk(rx_level == '0, "R11 levels untouched", int'(rx_level), 0);
        end
        run_pkt(3, mtog[3], 2, 1'b0);
        drain(3);
        if (mfn[3]) clear_nak(3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule